// File: doc/BRIEF.md
# Logic Self-Test Pattern Engine

This block drives the built-in self-test of one logic partition. When a run is requested it captures its configuration, seeds a 16-bit pseudo-random generator and a 64-bit signature register, and then steps a sequence of patterns. Each pattern shifts the chains, then pulses a capture enable. The chains are fed from the generator, and what they shift out is folded into the signature register. A pattern counter walks from a programmable first value to a programmable last value. When the last capture has been taken, a done flag is raised. The signature is offered in full and also through a 32-bit window that a select input points at either half.

All shift and capture timing comes from single-cycle enable pulses made by a divider on the fast clock, never from a derived clock. The scan chains and the logic under test live outside the block. The block drives their serial inputs, a shift enable and a capture enable, and it reads back their serial outputs. Any chain can be masked, so that its input is held at 1.

Top module: `selftest_engine`

## Requirements
- R1: A high `run_req` sampled on a clock edge while the engine is idle or done starts a run. `done` goes low on that edge. With `ratio` the divider value, `N` the pattern count and `L` = CHAIN_LEN, `done` rises exactly 2 + ratio·N·(L+1) edges later.
- R2: The divider value is `cfg_div`, sampled when the run starts. A value of 0 selects 8, which is also the value held after reset. Shift and capture enables are single-cycle pulses spaced `ratio` cycles apart.
- R3: Each pattern consists of L `shift_en` pulses followed by one `capture_en` pulse. The pattern counter runs from `cfg_pat_start` to `cfg_pat_end` inclusive, giving N = end − start + 1 patterns. `shift_en`, `capture_en` and `done` are never high together.
- R4: The generator state p is loaded from `cfg_seed`; a seed of 0 loads 1 instead. On each shift pulse, chain i receives p[i], and p then becomes {p[14:0], p[15]^p[14]^p[12]^p[3]}.
- R5: The signature m is loaded from `cfg_sig_init`. On each shift pulse, m becomes {m[62:0], m[63]^m[62]^m[60]^m[59]} XOR the zero-extended `scan_out` vector, so chain i lands on bit i. Capture pulses leave m unchanged.
- R6: Every chain whose bit in `cfg_chain_mask` is 1 (the mask is sampled at run start) receives a constant 1 on every shift pulse.
- R7: While `done` is high and no run is requested, `signature` holds its value.
- R8: `sig_word` shows `signature[31:0]` when `word_sel` is 0 and `signature[63:32]` when it is 1, in the same cycle.
- R9: During a run, `run_req` and every `cfg_*` input are ignored. The timing and the final signature depend only on the values sampled when the run started.
- R10: After reset `done`, `shift_en` and `capture_en` are low and `signature` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_req | input | 1 | Run request, sampled when idle or done |
| cfg_div | input | DIV_W | Slow-enable divider value, 0 selects 8 |
| cfg_pat_start | input | CNT_W | First pattern counter value |
| cfg_pat_end | input | CNT_W | Last pattern counter value |
| cfg_seed | input | PRPG_W | Generator seed |
| cfg_sig_init | input | 64 | Signature start value |
| cfg_chain_mask | input | NUM_CHAINS | Chains forced to 1 |
| scan_out | input | NUM_CHAINS | Serial outputs of the chains |
| scan_in | output | NUM_CHAINS | Serial inputs of the chains |
| shift_en | output | 1 | One-cycle shift pulse |
| capture_en | output | 1 | One-cycle capture pulse |
| done | output | 1 | Run finished |
| signature | output | 64 | Full signature register |
| word_sel | input | 1 | Half select for sig_word |
| sig_word | output | 32 | Selected signature half |

## Verification
Two events can share one edge: the final capture pulse that ends a run, and a run request that is already waiting. The bench raises `run_req` early and holds it high, so the request is seen during the run (where it must be ignored), and then on the first edge of the done state, where it must restart the engine. The bench judges this by three results: `done` lasts exactly one cycle; the second done edge arrives at the latency predicted from that restart edge; and the second signature matches a prediction that continues from the chain contents left by the first run.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
    localparam int SIG_W  = 64;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_SHIFT,
        ST_CAPT,
        ST_DONE
    } st_e;
endpackage

// File: rtl/st_slow_tick.sv
module st_slow_tick #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    assign tick = enable && (div_q.cnt == ratio - DIV_W'(1));

    always_comb begin
        div_d = div_q;
        if (clear) begin
            div_d.cnt = '0;
        end else if (enable) begin
            div_d.cnt = tick ? '0 : div_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ratio > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/st_prpg.sv
module st_prpg #(
    parameter int            W    = 16,
    parameter int            NC   = 4,
    parameter logic [W-1:0]  TAPS = 16'hD008
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  seed,
    input  logic          step,
    input  logic [NC-1:0] mask,
    output logic [NC-1:0] chain_in
);
    typedef struct packed {
        logic [W-1:0] lfsr;
    } gen_t;

    gen_t gen_d, gen_q;

    assign chain_in = gen_q.lfsr[NC-1:0] | mask;

    always_comb begin
        gen_d = gen_q;
        if (load) begin
            gen_d.lfsr = (seed == '0) ? W'(1) : seed;
        end else if (step) begin
            gen_d.lfsr = {gen_q.lfsr[W-2:0], ^(gen_q.lfsr & TAPS)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= W'(1);
        else        gen_q <= gen_d;
    end

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (gen_q.lfsr != '0));
endmodule

// File: rtl/st_misr.sv
module st_misr #(
    parameter int           W    = 64,
    parameter int           NC   = 4,
    parameter logic [W-1:0] TAPS = 64'hD800_0000_0000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  init,
    input  logic          step,
    input  logic [NC-1:0] din,
    output logic [W-1:0]  sig
);
    typedef struct packed {
        logic [W-1:0] reg_v;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    assign sig = cmp_q.reg_v;

    always_comb begin
        cmp_d = cmp_q;
        if (load) begin
            cmp_d.reg_v = init;
        end else if (step) begin
            cmp_d.reg_v = {cmp_q.reg_v[W-2:0], ^(cmp_q.reg_v & TAPS)}
                        ^ {{(W-NC){1'b0}}, din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(sig));
endmodule

// File: rtl/selftest_engine.sv
module selftest_engine
    import selftest_pkg::*;
#(
    parameter int NUM_CHAINS = 4,
    parameter int CHAIN_LEN  = 8,
    parameter int PRPG_W     = 16,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 4,
    parameter int DEF_DIV    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_req,
    input  logic [DIV_W-1:0]      cfg_div,
    input  logic [CNT_W-1:0]      cfg_pat_start,
    input  logic [CNT_W-1:0]      cfg_pat_end,
    input  logic [PRPG_W-1:0]     cfg_seed,
    input  logic [SIG_W-1:0]      cfg_sig_init,
    input  logic [NUM_CHAINS-1:0] cfg_chain_mask,
    input  logic [NUM_CHAINS-1:0] scan_out,
    output logic [NUM_CHAINS-1:0] scan_in,
    output logic                  shift_en,
    output logic                  capture_en,
    output logic                  done,
    output logic [SIG_W-1:0]      signature,
    input  logic                  word_sel,
    output logic [WORD_W-1:0]     sig_word
);
    localparam int SH_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [SH_W-1:0] SH_LAST = SH_W'(CHAIN_LEN - 1);

    typedef struct packed {
        st_e                   st;
        logic                  init_cnt;
        logic [SH_W-1:0]       sh;
        logic [CNT_W-1:0]      pat;
        logic [CNT_W-1:0]      pat_end;
        logic [NUM_CHAINS-1:0] mask;
        logic [DIV_W-1:0]      ratio;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;
    logic tick;
    logic running;

    assign accept  = run_req && (ctl_q.st == ST_IDLE || ctl_q.st == ST_DONE);
    assign running = (ctl_q.st == ST_SHIFT) || (ctl_q.st == ST_CAPT);

    assign shift_en   = (ctl_q.st == ST_SHIFT) && tick;
    assign capture_en = (ctl_q.st == ST_CAPT) && tick;
    assign done       = (ctl_q.st == ST_DONE);

    st_slow_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .enable (running),
        .ratio  (ctl_q.ratio),
        .tick   (tick)
    );

    st_prpg #(.W(PRPG_W), .NC(NUM_CHAINS)) u_prpg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .seed     (cfg_seed),
        .step     (shift_en),
        .mask     (ctl_q.mask),
        .chain_in (scan_in)
    );

    st_misr #(.W(SIG_W), .NC(NUM_CHAINS)) u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .init  (cfg_sig_init),
        .step  (shift_en),
        .din   (scan_out),
        .sig   (signature)
    );

    assign sig_word = word_sel ? signature[SIG_W-1:WORD_W] : signature[WORD_W-1:0];

    always_comb begin
        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.st       = ST_INIT;
            ctl_d.init_cnt = 1'b0;
            ctl_d.sh       = '0;
            ctl_d.pat      = cfg_pat_start;
            ctl_d.pat_end  = cfg_pat_end;
            ctl_d.mask     = cfg_chain_mask;
            ctl_d.ratio    = (cfg_div == '0) ? DIV_W'(DEF_DIV) : cfg_div;
        end else begin
            unique case (ctl_q.st)
                ST_INIT: begin
                    if (ctl_q.init_cnt) ctl_d.st = ST_SHIFT;
                    ctl_d.init_cnt = 1'b1;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (ctl_q.sh == SH_LAST) begin
                            ctl_d.sh = '0;
                            ctl_d.st = ST_CAPT;
                        end else begin
                            ctl_d.sh = ctl_q.sh + SH_W'(1);
                        end
                    end
                end
                ST_CAPT: begin
                    if (tick) begin
                        if (ctl_q.pat == ctl_q.pat_end) begin
                            ctl_d.st = ST_DONE;
                        end else begin
                            ctl_d.pat = ctl_q.pat + CNT_W'(1);
                            ctl_d.st  = ST_SHIFT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.ratio <= DIV_W'(DEF_DIV);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R3
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_en, capture_en, done}));

    // R1
    done_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(capture_en));

    // R6
    masked_chain_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> ((scan_in & ctl_q.mask) == ctl_q.mask));

    // R7
    frozen_signature_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !run_req) |=> $stable(signature));
endmodule

// File: tb/selftest_engine_tb_top.sv
module selftest_engine_tb_top;
    localparam int NC = 4;
    localparam int L  = 8;
    localparam logic [L-1:0] CAPC = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 1'b0;
    logic [3:0]  cfg_div = '0;
    logic [15:0] cfg_pat_start = '0, cfg_pat_end = '0, cfg_seed = '0;
    logic [63:0] cfg_sig_init = '0;
    logic [NC-1:0] cfg_chain_mask = '0;
    logic [NC-1:0] scan_out, scan_in;
    logic shift_en, capture_en, done;
    logic [63:0] signature;
    logic word_sel = 1'b0;
    logic [31:0] sig_word;

    always #10 clk = ~clk;

    selftest_engine dut_i (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .cfg_div(cfg_div),
        .cfg_pat_start(cfg_pat_start), .cfg_pat_end(cfg_pat_end),
        .cfg_seed(cfg_seed), .cfg_sig_init(cfg_sig_init),
        .cfg_chain_mask(cfg_chain_mask), .scan_out(scan_out), .scan_in(scan_in),
        .shift_en(shift_en), .capture_en(capture_en), .done(done),
        .signature(signature), .word_sel(word_sel), .sig_word(sig_word)
    );

    // chain emulation: shift on shift_en, fixed XOR transform on capture
    logic [L-1:0] ch [NC];
    always_ff @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < NC; i++) begin
            if (!rst_n)          ch[i] <= '0;
            else if (capture_en) ch[i] <= ch[i] ^ CAPC;
            else if (shift_en)   ch[i] <= {ch[i][L-2:0], scan_in[i]};
        end
    end
    always_comb for (int i = 0; i < NC; i++) scan_out[i] = ch[i][L-1];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model
    logic [L-1:0] ref_ch [NC];
    function automatic logic [15:0] p_next(input logic [15:0] p);
        return {p[14:0], p[15] ^ p[14] ^ p[12] ^ p[3]};
    endfunction
    function automatic logic [63:0] m_next(input logic [63:0] m, input logic [NC-1:0] so);
        return {m[62:0], m[63] ^ m[62] ^ m[60] ^ m[59]} ^ {{(64-NC){1'b0}}, so};
    endfunction

    task automatic predict(input logic [15:0] seed, input logic [63:0] init,
                           input logic [NC-1:0] mask, input int npat,
                           output logic [63:0] sig);
        logic [15:0] p;
        logic [63:0] m;
        logic [NC-1:0] so;
        p = (seed == 16'd0) ? 16'd1 : seed;
        m = init;
        for (int k = 0; k < npat; k++) begin
            for (int s = 0; s < L; s++) begin
                for (int i = 0; i < NC; i++) so[i] = ref_ch[i][L-1];
                m = m_next(m, so);
                for (int i = 0; i < NC; i++) ref_ch[i] = {ref_ch[i][L-2:0], mask[i] | p[i]};
                p = p_next(p);
            end
            for (int i = 0; i < NC; i++) ref_ch[i] = ref_ch[i] ^ CAPC;
        end
        sig = m;
    endtask

    typedef struct {
        int          done_cyc;
        logic [63:0] sig;
        string       tag;
    } exp_t;
    exp_t q[$];
    logic [63:0] last_sig = '0;
    logic [NC-1:0] cur_mask = '0;
    int mask_bad = 0;
    logic done_prev = 1'b0;

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && shift_en && ((scan_in & cur_mask) != cur_mask)) mask_bad++;
            if (rst_n && done && !done_prev) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected done", 64'(cyc), 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.done_cyc, "R1 R2 R3", "done edge", 64'(cyc), 64'(e.done_cyc));
                    chk(signature === e.sig, e.tag, "signature", signature, e.sig);
                    word_sel = 1'b0;
                    #1 chk(sig_word === e.sig[31:0], "R8", "low word", 64'(sig_word), 64'(e.sig[31:0]));
                    word_sel = 1'b1;
                    #1 chk(sig_word === e.sig[63:32], "R8", "high word", 64'(sig_word), 64'(e.sig[63:32]));
                    word_sel = 1'b0;
                end
            end
            done_prev = done;
        end
    end

    task automatic run_one(input logic [3:0] div, input logic [15:0] ps, pe, seed,
                           input logic [63:0] init, input logic [NC-1:0] mask,
                           input bit poke, input string tag);
        exp_t e;
        int c0, r, npat;
        @(negedge clk);
        cfg_div = div; cfg_pat_start = ps; cfg_pat_end = pe; cfg_seed = seed;
        cfg_sig_init = init; cfg_chain_mask = mask; cur_mask = mask; mask_bad = 0;
        run_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        c0 = cyc;
        run_req = 1'b0;
        r = (div == 4'd0) ? 8 : int'(div);
        npat = int'(pe) - int'(ps) + 1;
        predict(seed, init, mask, npat, e.sig);
        e.done_cyc = c0 + 2 + r * npat * (L + 1);
        e.tag = tag;
        q.push_back(e);
        last_sig = e.sig;
        if (poke) begin
            repeat (15) @(negedge clk);
            run_req = 1'b1; cfg_seed = ~seed; cfg_div = 4'd1;
            cfg_chain_mask = ~mask; cfg_sig_init = ~init; cfg_pat_end = pe + 16'd5;
            @(negedge clk);
            run_req = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    bit finished = 1'b0;
    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) ref_ch[i] = '0;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(!done && !shift_en && !capture_en, "R10", "controls in reset",
            {61'd0, done, shift_en, capture_en}, 64'd0);
        chk(signature == 64'd0, "R10", "signature in reset", signature, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done && !shift_en, "R10", "idle after reset", {62'd0, done, shift_en}, 64'd0);

        // default divider, two patterns
        run_one(4'd0, 16'd0, 16'd1, 16'hACE1, 64'h0123_4567_89AB_CDEF, 4'b0000, 1'b0, "R5");
        repeat (12) @(negedge clk);
        chk(done && signature === last_sig, "R7", "frozen after done", signature, last_sig);

        // fast divider, chain 0 masked, three patterns
        run_one(4'd1, 16'd5, 16'd7, 16'h1D2C, 64'd0, 4'b0001, 1'b0, "R6");
        chk(mask_bad == 0, "R6", "masked chain held at 1", 64'(mask_bad), 64'd0);

        // zero seed, single pattern
        run_one(4'd3, 16'd10, 16'd10, 16'h0000, {64{1'b1}}, 4'b1010, 1'b0, "R4");
        chk(mask_bad == 0, "R6", "two masked chains", 64'(mask_bad), 64'd0);

        // requests and config changes during the run
        run_one(4'd2, 16'd0, 16'd2, 16'h0F0F, 64'hDEAD_BEEF_0000_1111, 4'b0000, 1'b1, "R9");
        repeat (6) @(negedge clk);
        chk(done && signature === last_sig, "R9", "no restart from mid-run request", signature, last_sig);

        // held request: restart on the first done cycle
        begin
            exp_t e1, e2;
            int c0, start2;
            @(negedge clk);
            cfg_div = 4'd1; cfg_pat_start = 16'd0; cfg_pat_end = 16'd0; cfg_seed = 16'h8001;
            cfg_sig_init = 64'h1111_2222_3333_4444; cfg_chain_mask = 4'b0100; cur_mask = 4'b0100;
            run_req = 1'b1;
            @(posedge clk);
            @(negedge clk);
            c0 = cyc;
            predict(16'h8001, 64'h1111_2222_3333_4444, 4'b0100, 1, e1.sig);
            e1.done_cyc = c0 + 2 + (L + 1);
            e1.tag = "R1";
            q.push_back(e1);
            start2 = e1.done_cyc + 1;
            predict(16'h8001, 64'h1111_2222_3333_4444, 4'b0100, 1, e2.sig);
            e2.done_cyc = start2 + 2 + (L + 1);
            e2.tag = "R1";
            q.push_back(e2);
            while (cyc < start2) @(negedge clk);
            run_req = 1'b0;
            chk(!done, "R1", "done lasts one cycle on held request", {63'd0, done}, 64'd0);
            while (q.size() != 0) @(negedge clk);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule